// File: doc/BRIEF.md
# Dual-Product Multiply-Add Unit

This block forms two products from two independent operand pairs and merges them in a single adder/subtractor stage. The output is the first product plus the second product, or the first product minus the second product. A run-time select chooses between the two. A second run-time select makes all four operands two's complement or unsigned. Both selects travel through the same register stages as the data, so each result uses the controls that were presented with its own operands.

Three register stages are each chosen by a parameter: an operand stage in front of the multipliers, a stage between the multipliers and the combiner, and a stage on the result. Latency is therefore 0 to 3 clock cycles.

For cascading, the second operand pair leaves the block after the operand stage on dedicated chain outputs. A neighbouring unit can take them in on its chain inputs, which replace its first operand pair when the chain select is high.

Top module: `mul_add_pair`

## Requirements
- R1: With the subtract select low, `result` equals A0·B0 + A1·B1, written into `M_W+N_W+1` bits.
- R2: With the subtract select high, `result` equals A0·B0 − A1·B1 as a two's-complement value of `M_W+N_W+1` bits. This also holds in unsigned mode, where the difference may be negative.
- R3: With `signed_mode` high, all four operands are two's-complement numbers and each product is sign-extended. With it low, all four are unsigned and each product is zero-extended.
- R4: The output never overflows. The unsigned worst case (2^M_W−1)·(2^N_W−1)·2 and the signed extremes, including (−2^(M_W−1))·(−2^(N_W−1)) minus the most negative product, come out exact.
- R5: The latency from operands to `result` is IN_REG+PIPE_REG+OUT_REG clock cycles. With the default configuration of all stages enabled, this is 3 cycles.
- R6: While `ce` is low, every enabled register holds its value. `result` and the chain outputs stay unchanged, and operands presented during that time are ignored.
- R7: `rst` is synchronous. Sampled high at a clock edge, it clears every enabled register to zero, so `result` and the chain outputs read 0 after that edge.
- R8: `signed_mode` and `sub_sel` are delayed along with the data. Changing them every cycle in a continuous stream gives each result the controls presented with its own operands.
- R9: `a_chain_out` and `b_chain_out` carry the A1 and B1 values after the operand stage, which is one cycle after they are presented by default.
- R10: With `chain_sel` high, `a_chain_in` and `b_chain_in` replace `a0` and `b0` as the first operand pair. The `a0` and `b0` ports are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all register stages |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned |
| sub_sel | input | 1 | 1: subtract second product, 0: add it |
| chain_sel | input | 1 | 1: first operand pair taken from chain inputs |
| a0 | input | M_W | Multiplicand of first product |
| b0 | input | N_W | Multiplier of first product |
| a1 | input | M_W | Multiplicand of second product |
| b1 | input | N_W | Multiplier of second product |
| a_chain_in | input | M_W | Cascade multiplicand input |
| b_chain_in | input | N_W | Cascade multiplier input |
| a_chain_out | output | M_W | A1 after the operand stage |
| b_chain_out | output | N_W | B1 after the operand stage |
| result | output | M_W+N_W+1 | Combined sum or difference |

## Verification
The result property compares `result` against the inputs seen as many edges earlier as the latency. It fires only after that many consecutive edges with `ce` high and `rst` low. It therefore assumes that any stall or reset flushes the comparison window, and that inputs are stable around each sampled edge. The bench drives every input at the falling edge and holds it through the next rising edge. It restarts a full latency of enabled cycles after each reset and each stall, so every checked value comes from operands that moved through the whole pipeline.

// File: rtl/mad_pkg.sv
package mad_pkg;

    localparam int DEF_M_W = 8;
    localparam int DEF_N_W = 8;

    typedef struct packed {
        logic sgn;
        logic sub;
    } mad_ctrl_t;

endpackage

// File: rtl/mad_stage.sv
module mad_stage #(
    parameter int W      = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (ENABLE) begin : g_reg
            logic [W-1:0] data_d;
            logic [W-1:0] data_q;

            always_comb begin
                data_d = data_q;
                if (ce) begin
                    data_d = din;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q <= '0;
                end else begin
                    data_q <= data_d;
                end
            end

            assign dout = data_q;
        end else begin : g_bypass
            logic unused_ok;
            assign unused_ok = &{1'b0, clk, rst, ce};
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/mad_mult.sv
module mad_mult #(
    parameter int M_W = 8,
    parameter int N_W = 8,
    localparam int P_W = M_W + N_W
) (
    input  logic           sgn,
    input  logic [M_W-1:0] a,
    input  logic [N_W-1:0] b,
    output logic [P_W-1:0] prod
);

    logic [P_W-1:0] a_ext;
    logic [P_W-1:0] b_ext;
    logic           a_fill;
    logic           b_fill;

    always_comb begin
        a_fill = sgn & a[M_W-1];
        b_fill = sgn & b[N_W-1];
        a_ext  = {{N_W{a_fill}}, a};
        b_ext  = {{M_W{b_fill}}, b};
        prod   = a_ext * b_ext;
    end

endmodule

// File: rtl/mad_combine.sv
module mad_combine #(
    parameter int P_W = 16,
    localparam int R_W = P_W + 1
) (
    input  logic           sgn,
    input  logic           sub,
    input  logic [P_W-1:0] p0,
    input  logic [P_W-1:0] p1,
    output logic [R_W-1:0] sum
);

    logic [R_W-1:0] e0;
    logic [R_W-1:0] e1;

    always_comb begin
        e0 = {sgn & p0[P_W-1], p0};
        e1 = {sgn & p1[P_W-1], p1};
        if (sub) begin
            sum = e0 - e1;
        end else begin
            sum = e0 + e1;
        end
    end

endmodule

// File: rtl/mul_add_pair.sv
module mul_add_pair #(
    parameter int M_W      = mad_pkg::DEF_M_W,
    parameter int N_W      = mad_pkg::DEF_N_W,
    parameter bit IN_REG   = 1'b1,
    parameter bit PIPE_REG = 1'b1,
    parameter bit OUT_REG  = 1'b1,
    localparam int P_W = M_W + N_W,
    localparam int R_W = P_W + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ce,
    input  logic           signed_mode,
    input  logic           sub_sel,
    input  logic           chain_sel,
    input  logic [M_W-1:0] a0,
    input  logic [N_W-1:0] b0,
    input  logic [M_W-1:0] a1,
    input  logic [N_W-1:0] b1,
    input  logic [M_W-1:0] a_chain_in,
    input  logic [N_W-1:0] b_chain_in,
    output logic [M_W-1:0] a_chain_out,
    output logic [N_W-1:0] b_chain_out,
    output logic [R_W-1:0] result
);

    typedef struct packed {
        mad_pkg::mad_ctrl_t ctl;
        logic [M_W-1:0]     a0;
        logic [N_W-1:0]     b0;
        logic [M_W-1:0]     a1;
        logic [N_W-1:0]     b1;
    } op_t;

    typedef struct packed {
        mad_pkg::mad_ctrl_t ctl;
        logic [P_W-1:0]     p0;
        logic [P_W-1:0]     p1;
    } prod_t;

    localparam int OP_W   = $bits(op_t);
    localparam int PROD_W = $bits(prod_t);

    op_t            op_in;
    op_t            op_s1;
    prod_t          pr_in;
    prod_t          pr_s2;
    logic [R_W-1:0] sum_in;
    logic [R_W-1:0] sum_s3;

    always_comb begin
        op_in.ctl.sgn = signed_mode;
        op_in.ctl.sub = sub_sel;
        op_in.a0      = chain_sel ? a_chain_in : a0;
        op_in.b0      = chain_sel ? b_chain_in : b0;
        op_in.a1      = a1;
        op_in.b1      = b1;
    end

    mad_stage #(.W(OP_W), .ENABLE(IN_REG)) u_in_stage (
        .clk  (clk),
        .rst  (rst),
        .ce   (ce),
        .din  (op_in),
        .dout (op_s1)
    );

    assign a_chain_out = op_s1.a1;
    assign b_chain_out = op_s1.b1;

    mad_mult #(.M_W(M_W), .N_W(N_W)) u_mult0 (
        .sgn  (op_s1.ctl.sgn),
        .a    (op_s1.a0),
        .b    (op_s1.b0),
        .prod (pr_in.p0)
    );

    mad_mult #(.M_W(M_W), .N_W(N_W)) u_mult1 (
        .sgn  (op_s1.ctl.sgn),
        .a    (op_s1.a1),
        .b    (op_s1.b1),
        .prod (pr_in.p1)
    );

    assign pr_in.ctl = op_s1.ctl;

    mad_stage #(.W(PROD_W), .ENABLE(PIPE_REG)) u_pipe_stage (
        .clk  (clk),
        .rst  (rst),
        .ce   (ce),
        .din  (pr_in),
        .dout (pr_s2)
    );

    mad_combine #(.P_W(P_W)) u_combine (
        .sgn (pr_s2.ctl.sgn),
        .sub (pr_s2.ctl.sub),
        .p0  (pr_s2.p0),
        .p1  (pr_s2.p1),
        .sum (sum_in)
    );

    mad_stage #(.W(R_W), .ENABLE(OUT_REG)) u_out_stage (
        .clk  (clk),
        .rst  (rst),
        .ce   (ce),
        .din  (sum_in),
        .dout (sum_s3)
    );

    assign result = sum_s3;

endmodule

// File: rtl/mad_check.sv
module mad_check #(
    parameter int M_W      = 8,
    parameter int N_W      = 8,
    parameter bit IN_REG   = 1'b1,
    parameter bit PIPE_REG = 1'b1,
    parameter bit OUT_REG  = 1'b1,
    localparam int P_W = M_W + N_W,
    localparam int R_W = P_W + 1,
    localparam int LAT = int'(IN_REG) + int'(PIPE_REG) + int'(OUT_REG)
) (
    input logic           clk,
    input logic           rst,
    input logic           ce,
    input logic           signed_mode,
    input logic           sub_sel,
    input logic           chain_sel,
    input logic [M_W-1:0] a0,
    input logic [N_W-1:0] b0,
    input logic [M_W-1:0] a1,
    input logic [N_W-1:0] b1,
    input logic [M_W-1:0] a_chain_in,
    input logic [N_W-1:0] b_chain_in,
    input logic [M_W-1:0] a_chain_out,
    input logic [N_W-1:0] b_chain_out,
    input logic [R_W-1:0] result
);

    logic [1:0]     run_cnt = 2'd0;
    logic [M_W-1:0] ra0;
    logic [N_W-1:0] rb0;
    logic [R_W-1:0] xa0, xb0, xa1, xb1;
    logic [R_W-1:0] ref_now;

    always_ff @(posedge clk) begin
        if (rst || !ce) begin
            run_cnt <= 2'd0;
        end else if (run_cnt != 2'd3) begin
            run_cnt <= run_cnt + 2'd1;
        end
    end

    always_comb begin
        ra0 = chain_sel ? a_chain_in : a0;
        rb0 = chain_sel ? b_chain_in : b0;
        xa0 = {{(R_W-M_W){signed_mode & ra0[M_W-1]}}, ra0};
        xb0 = {{(R_W-N_W){signed_mode & rb0[N_W-1]}}, rb0};
        xa1 = {{(R_W-M_W){signed_mode & a1[M_W-1]}}, a1};
        xb1 = {{(R_W-N_W){signed_mode & b1[N_W-1]}}, b1};
        ref_now = sub_sel ? (xa0 * xb0) - (xa1 * xb1) : (xa0 * xb0) + (xa1 * xb1);
    end

    generate
        if (LAT > 0) begin : g_lat
            // R1 R2 R3 R4 R5 R8 R10: result matches the operands LAT edges back
            a_r1_result: assert property (@(posedge clk) disable iff (rst)
                (int'(run_cnt) >= LAT) |-> (result == $past(ref_now, LAT)));
        end
        if (OUT_REG) begin : g_out
            a_r6_hold: assert property (@(posedge clk) disable iff (rst)
                (!ce) |=> $stable(result));
            a_r7_reset: assert property (@(posedge clk)
                rst |=> (result == '0));
        end
        if (IN_REG) begin : g_in
            a_r9_chain: assert property (@(posedge clk) disable iff (rst)
                ce |=> ((a_chain_out == $past(a1)) && (b_chain_out == $past(b1))));
            a_r6_chain_hold: assert property (@(posedge clk) disable iff (rst)
                (!ce) |=> ($stable(a_chain_out) && $stable(b_chain_out)));
            a_r7_chain_reset: assert property (@(posedge clk)
                rst |=> ((a_chain_out == '0) && (b_chain_out == '0)));
        end
    endgenerate

endmodule

bind mul_add_pair mad_check #(
    .M_W(M_W), .N_W(N_W), .IN_REG(IN_REG), .PIPE_REG(PIPE_REG), .OUT_REG(OUT_REG)
) u_mad_check (
    .clk         (clk),
    .rst         (rst),
    .ce          (ce),
    .signed_mode (signed_mode),
    .sub_sel     (sub_sel),
    .chain_sel   (chain_sel),
    .a0          (a0),
    .b0          (b0),
    .a1          (a1),
    .b1          (b1),
    .a_chain_in  (a_chain_in),
    .b_chain_in  (b_chain_in),
    .a_chain_out (a_chain_out),
    .b_chain_out (b_chain_out),
    .result      (result)
);

// File: tb/tb_mul_add_pair.sv
`timescale 1ns/1ps
module tb_mul_add_pair;

    localparam int M_W = 8;
    localparam int N_W = 8;
    localparam int R_W = M_W + N_W + 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ce = 1'b0;
    logic           signed_mode = 1'b0;
    logic           sub_sel = 1'b0;
    logic           chain_sel = 1'b0;
    logic [M_W-1:0] a0 = '0, a1 = '0, a_chain_in = '0;
    logic [N_W-1:0] b0 = '0, b1 = '0, b_chain_in = '0;
    logic [M_W-1:0] a_chain_out;
    logic [N_W-1:0] b_chain_out;
    logic [R_W-1:0] result;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    mul_add_pair dut (
        .clk(clk), .rst(rst), .ce(ce), .signed_mode(signed_mode), .sub_sel(sub_sel),
        .chain_sel(chain_sel), .a0(a0), .b0(b0), .a1(a1), .b1(b1),
        .a_chain_in(a_chain_in), .b_chain_in(b_chain_in),
        .a_chain_out(a_chain_out), .b_chain_out(b_chain_out), .result(result)
    );

    function automatic logic [R_W-1:0] expect_val(input logic s, input logic sb,
        input logic [7:0] x0, input logic [7:0] y0, input logic [7:0] x1, input logic [7:0] y1);
        int i0, j0, i1, j1, r;
        if (s) begin
            i0 = int'($signed(x0)); j0 = int'($signed(y0));
            i1 = int'($signed(x1)); j1 = int'($signed(y1));
        end else begin
            i0 = int'(x0); j0 = int'(y0); i1 = int'(x1); j1 = int'(y1);
        end
        r = sb ? (i0 * j0 - i1 * j1) : (i0 * j0 + i1 * j1);
        return r[R_W-1:0];
    endfunction

    task automatic check(input string req, input logic [R_W-1:0] got, input logic [R_W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic drive(input logic s, input logic sb, input logic [7:0] x0, input logic [7:0] y0,
                         input logic [7:0] x1, input logic [7:0] y1);
        signed_mode = s; sub_sel = sb; a0 = x0; b0 = y0; a1 = x1; b1 = y1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; ce = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic one_vec(input string req, input logic s, input logic sb,
        input logic [7:0] x0, input logic [7:0] y0, input logic [7:0] x1, input logic [7:0] y1);
        @(negedge clk);
        drive(s, sb, x0, y0, x1, y1);
        repeat (3) @(negedge clk);
        check(req, result, expect_val(s, sb, x0, y0, x1, y1));
    endtask

    task automatic t_reset();
        drive(1'b1, 1'b0, 8'h7f, 8'h7f, 8'h11, 8'h22);
        @(negedge clk); rst = 1'b0; ce = 1'b1;
        repeat (4) @(negedge clk);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R7 result after reset", result, '0);
        check("R7 chain after reset", {9'd0, a_chain_out}, '0);
        rst = 1'b0;
    endtask

    task automatic t_add();
        one_vec("R1 unsigned add", 1'b0, 1'b0, 8'd12, 8'd34, 8'd56, 8'd78);
        one_vec("R1 zero operands", 1'b0, 1'b0, 8'd0, 8'd200, 8'd0, 8'd9);
    endtask

    task automatic t_sub();
        one_vec("R2 unsigned sub positive", 1'b0, 1'b1, 8'd200, 8'd100, 8'd3, 8'd5);
        one_vec("R2 unsigned sub negative", 1'b0, 1'b1, 8'd1, 8'd1, 8'd255, 8'd255);
    endtask

    task automatic t_signed();
        one_vec("R3 signed add mixed", 1'b1, 1'b0, 8'hf6, 8'd7, 8'd5, 8'hfd);
        one_vec("R3 unsigned view same bits", 1'b0, 1'b0, 8'hf6, 8'd7, 8'd5, 8'hfd);
    endtask

    task automatic t_extremes();
        one_vec("R4 unsigned max add", 1'b0, 1'b0, 8'hff, 8'hff, 8'hff, 8'hff);
        one_vec("R4 signed max sub", 1'b1, 1'b1, 8'h80, 8'h80, 8'h80, 8'h7f);
        one_vec("R4 signed max add", 1'b1, 1'b0, 8'h80, 8'h80, 8'h80, 8'h80);
    endtask

    task automatic t_latency();
        do_reset();
        drive(1'b0, 1'b0, 8'd9, 8'd9, 8'd1, 8'd1);
        @(negedge clk);
        drive(1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0);
        @(negedge clk);
        check("R5 not before 3 cycles (2)", result, '0);
        @(negedge clk);
        check("R5 value at 3 cycles", result, 17'd82);
    endtask

    task automatic t_stream();
        logic [R_W-1:0] expq [0:7];
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i >= 3) check("R8 stream controls aligned", result, expq[i-3]);
            drive(i[0], i[1], 8'(8'hf0 + i), 8'(3 + i), 8'(8'h81 + 5 * i), 8'(8'hc0 - i));
            expq[i] = expect_val(i[0], i[1], 8'(8'hf0 + i), 8'(3 + i), 8'(8'h81 + 5 * i), 8'(8'hc0 - i));
        end
        for (int i = 8; i < 11; i++) begin
            @(negedge clk);
            check("R8 stream drain", result, expq[i-3]);
        end
    endtask

    task automatic t_hold();
        logic [R_W-1:0] held;
        one_vec("R6 before stall", 1'b0, 1'b0, 8'd20, 8'd30, 8'd40, 8'd50);
        held = result;
        ce = 1'b0;
        drive(1'b1, 1'b1, 8'h99, 8'h88, 8'h77, 8'h66);
        repeat (4) @(negedge clk);
        check("R6 result held", result, held);
        check("R6 chain held", {9'd0, a_chain_out}, {9'd0, 8'd40});
        ce = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 resume after stall", result, expect_val(1'b1, 1'b1, 8'h99, 8'h88, 8'h77, 8'h66));
    endtask

    task automatic t_chain();
        @(negedge clk);
        drive(1'b0, 1'b0, 8'd1, 8'd1, 8'h5a, 8'ha5);
        @(negedge clk);
        check("R9 a chain out", {9'd0, a_chain_out}, {9'd0, 8'h5a});
        check("R9 b chain out", {9'd0, b_chain_out}, {9'd0, 8'ha5});
        @(negedge clk);
        chain_sel = 1'b1; a_chain_in = 8'd11; b_chain_in = 8'd13;
        drive(1'b0, 1'b0, 8'd250, 8'd250, 8'd2, 8'd3);
        repeat (3) @(negedge clk);
        check("R10 chain inputs used", result, 17'd149);
        chain_sel = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_signed();
        t_extremes();
        t_latency();
        t_stream();
        t_hold();
        t_chain();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule